// File: doc/BRIEF.md
# Register-Mapped Interrupt Aggregator

This block gathers a parameterized number of peripheral interrupt lines and drives a single request line to a processor. Each input is fixed at build time as edge- or level-sensitive. Detected events are held in a status register. The status register is masked by an enable register to form the pending set. A vector register reports the lowest-numbered pending input.

Software reaches eight word registers over a simple 32-bit read/write bus. The enable register can be written whole, or changed through separate write-1-to-set and write-1-to-clear aliases. A write-1 acknowledge register clears status bits. A two-bit master register gates both the output request and hardware capture. A read returns its data one cycle after the request, marked by a valid strobe.

Top module: `irq_hub`

## Requirements
- R1: The register map uses byte addresses, decoded from address bits [4:2]: 0x00 status, 0x04 pending, 0x08 enable, 0x0C acknowledge, 0x10 set-enable, 0x14 clear-enable, 0x18 vector, 0x1C master. Read data appears on `busRdata` with `busRdValid` high in the cycle after the read is accepted.
- R2: Master bit 0 gates the request output and master bit 1 gates hardware capture. Both bits read back exactly as written.
- R3: A write to acknowledge clears each status bit where the written word has a 1. Writing all ones clears every latched event.
- R4: A write to set-enable ORs the written bits into enable. A write to clear-enable clears enable wherever the written word has a 1.
- R5: A write to the enable register replaces it entirely, and writing zero disables every input.
- R6: Vector reads the index of the lowest-numbered pending input, or 0xFFFFFFFF when nothing is pending.
- R7: A level input (kind bit 0) sets its status bit every cycle it is high. An acknowledge while the source is still high therefore leaves the bit set.
- R8: An edge input (kind bit 1) sets status only on a rising edge against its previous sample, so a held-high input does not re-latch after an acknowledge. No input is captured while master bit 1 is clear.
- R9: `irqReq` is high exactly when some pending bit is set and both master bits are 1.
- R10: Pending equals status AND enable. Status, pending and enable bits at or above the input count read as zero.
- R11: Reset clears status, enable and master, so the vector reads all ones and `irqReq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access request this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| busRdValid | output | 1 | Read data valid, one cycle after a read |
| irqIn | input | NUM_IN | Peripheral interrupt inputs |
| irqReq | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to reach is the collision between an acknowledge and a source that is still asserted. For a level input the bit must come back at once. For an edge input held high it must stay clear. The stimulus holds a level line and an edge line high across the acknowledge write and then reads status. A second hard case is capture while master bit 1 is off. The bench pulses inputs with that bit clear, then switches capture on with the lines already low, and confirms that no stale edge appears.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  typedef enum logic [2:0] {
    SelStatus = 3'd0,
    SelPend   = 3'd1,
    SelEnable = 3'd2,
    SelAck    = 3'd3,
    SelSetEn  = 3'd4,
    SelClrEn  = 3'd5,
    SelVector = 3'd6,
    SelMaster = 3'd7
  } regSel_t;

  typedef struct packed {
    logic        wrEnable;
    logic        wrAck;
    logic        wrSetEn;
    logic        wrClrEn;
    logic        wrMaster;
    logic [31:0] data;
  } strobes_t;

endpackage

// File: rtl/irq_hub_ctrl.sv
module irq_hub_ctrl
  import irq_hub_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output strobes_t          stb,
  output regSel_t           rdSel,
  output logic              rdStrobe
);

  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + 2;

  regSel_t sel;
  logic    doWrite;
  logic    unusedAddrBits;

  assign sel            = regSel_t'(busAddr[IDX_HI:IDX_LO]);
  assign doWrite        = busSel && busWr;
  assign unusedAddrBits = ^{busAddr[IDX_LO-1:0], busAddr[ADDR_W-1:IDX_HI]};

  always_comb begin
    stb          = '0;
    stb.data     = busWdata;
    stb.wrEnable = doWrite && (sel == SelEnable);
    stb.wrAck    = doWrite && (sel == SelAck);
    stb.wrSetEn  = doWrite && (sel == SelSetEn);
    stb.wrClrEn  = doWrite && (sel == SelClrEn);
    stb.wrMaster = doWrite && (sel == SelMaster);
  end

  assign rdSel    = sel;
  assign rdStrobe = busSel && !busWr;

endmodule

// File: rtl/irq_hub_dp.sv
module irq_hub_dp
  import irq_hub_pkg::*;
#(
  parameter int          NUM_IN    = 8,
  parameter logic [31:0] EDGE_KIND = 32'h0000_000F
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  regSel_t           rdSel,
  input  logic              rdStrobe,
  input  logic [NUM_IN-1:0] irqIn,
  output logic [31:0]       busRdata,
  output logic              busRdValid,
  output logic              irqReq
);

  localparam int VEC_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
  localparam logic [NUM_IN-1:0] LEVEL_MASK = ~EDGE_KIND[NUM_IN-1:0];

  logic [NUM_IN-1:0] status, enable, prevIn, hit, pending, wrBits;
  logic [1:0]        master;
  logic [VEC_W-1:0]  vecIdx;
  logic [31:0]       vecWord;
  logic              anyPend, hwEn, reqEn;
  logic              unusedData;

  assign wrBits     = stb.data[NUM_IN-1:0];
  assign unusedData = ^stb.data;
  assign hwEn       = master[1];
  assign reqEn      = master[0];

  // per-input capture variant chosen by the kind parameter
  for (genvar i = 0; i < NUM_IN; i++) begin : g_cap
    if (EDGE_KIND[i]) begin : g_edge
      assign hit[i] = irqIn[i] & ~prevIn[i];
    end else begin : g_level
      assign hit[i] = irqIn[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status <= '0;
      enable <= '0;
      master <= '0;
      prevIn <= '0;
    end else begin
      prevIn <= irqIn;
      // capture wins over a same-cycle acknowledge
      status <= (status & ~(stb.wrAck ? wrBits : '0)) | (hwEn ? hit : '0);
      if (stb.wrEnable)     enable <= wrBits;
      else if (stb.wrSetEn) enable <= enable | wrBits;
      else if (stb.wrClrEn) enable <= enable & ~wrBits;
      if (stb.wrMaster)     master <= stb.data[1:0];
    end
  end

  assign pending = status & enable;
  assign anyPend = |pending;

  always_comb begin
    vecIdx = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (pending[i]) vecIdx = VEC_W'(i);
    end
  end

  assign vecWord = anyPend ? 32'(vecIdx) : 32'hFFFF_FFFF;
  assign irqReq  = anyPend && reqEn && hwEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata   <= '0;
      busRdValid <= 1'b0;
    end else begin
      busRdValid <= rdStrobe;
      if (rdStrobe) begin
        case (rdSel)
          SelStatus: busRdata <= 32'(status);
          SelPend:   busRdata <= 32'(pending);
          SelEnable: busRdata <= 32'(enable);
          SelVector: busRdata <= vecWord;
          SelMaster: busRdata <= 32'(master);
          default:   busRdata <= '0;
        endcase
      end
    end
  end

  // ---------------- assertions ----------------
  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrAck && !hwEn) |=> ((status & $past(wrBits)) == '0));

  p_set_or_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrSetEn && !stb.wrEnable) |=> ((enable & $past(wrBits)) == $past(wrBits)));

  p_clr_and_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrClrEn && !stb.wrEnable && !stb.wrSetEn) |=> ((enable & $past(wrBits)) == '0));

  p_direct_en_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEnable |=> (enable == $past(wrBits)));

  p_master_back_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrMaster |=> (master == $past(stb.data[1:0])));

  p_vec_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pending == '0) |-> (vecWord == 32'hFFFF_FFFF));

  p_level_relatch_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hwEn && ((irqIn & LEVEL_MASK) != '0)) |=>
      ((status & $past(irqIn & LEVEL_MASK)) == $past(irqIn & LEVEL_MASK)));

  p_no_capture_r8: assert property (@(posedge clk) disable iff (!rstN)
    !hwEn |=> ((status & ~$past(status)) == '0));

  p_req_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (master != 2'b11) |-> !irqReq);

endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int          NUM_IN    = 8,
  parameter logic [31:0] EDGE_KIND = 32'h0000_000F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [4:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busRdValid,
  input  logic [NUM_IN-1:0] irqIn,
  output logic              irqReq
);

  strobes_t stb;
  regSel_t  rdSel;
  logic     rdStrobe;

  irq_hub_ctrl #(.ADDR_W(5)) u_ctrl (
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .stb      (stb),
    .rdSel    (rdSel),
    .rdStrobe (rdStrobe)
  );

  irq_hub_dp #(.NUM_IN(NUM_IN), .EDGE_KIND(EDGE_KIND)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .rdSel      (rdSel),
    .rdStrobe   (rdStrobe),
    .irqIn      (irqIn),
    .busRdata   (busRdata),
    .busRdValid (busRdValid),
    .irqReq     (irqReq)
  );

endmodule

// File: tb/sim_irq_hub.sv
module sim_irq_hub;
  localparam int PERIOD = 10;
  localparam int NIN    = 8;

  localparam logic [4:0] A_STAT = 5'h00, A_PEND = 5'h04, A_EN = 5'h08, A_ACK = 5'h0C,
                         A_SET = 5'h10, A_CLR = 5'h14, A_VEC = 5'h18, A_MER = 5'h1C;

  logic clk = 0, rstN = 0, busSel = 0, busWr = 0, busRdValid, irqReq;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic [NIN-1:0] irqIn = '0;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  always #(PERIOD/2) clk = ~clk;

  irq_hub #(.NUM_IN(NIN), .EDGE_KIND(32'h0000_000F)) u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busRdValid(busRdValid),
    .irqIn(irqIn), .irqReq(irqReq));

  // monitor: pops expected read results as the design returns them
  always @(negedge clk) begin
    if (rstN && busRdValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected read data got=%h exp=none", busRdata);
      end else begin
        automatic logic [31:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        if (busRdata !== e) begin
          errors++;
          $display("FAIL %s got=%h exp=%h", t, busRdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWr = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    expQ.push_back(e); tagQ.push_back(t);
    busSel = 1; busWr = 0; busAddr = a;
    @(negedge clk);
    busSel = 0;
  endtask

  task automatic chkReq(input logic e, input string t);
    checks++;
    if (irqReq !== e) begin
      errors++;
      $display("FAIL %s irqReq got=%b exp=%b", t, irqReq, e);
    end
  endtask

  task automatic waitc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int b);
    @(negedge clk); irqIn[b] = 1'b1;
    @(negedge clk); @(negedge clk); irqIn[b] = 1'b0;
    waitc(1);
  endtask

  task automatic finishRun();
    waitc(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    waitc(50000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    waitc(3);
    rstN = 1;
    // R11 / R1 reset state
    rd(A_STAT, 32'h0, "R11 status after reset");
    rd(A_EN,   32'h0, "R11 enable after reset");
    rd(A_MER,  32'h0, "R11 master after reset");
    rd(A_VEC,  32'hFFFF_FFFF, "R11 vector after reset");
    chkReq(1'b0, "R11");
    // R2 master readback
    wr(A_MER, 32'h3); rd(A_MER, 32'h3, "R2 master=3");
    wr(A_MER, 32'h1); rd(A_MER, 32'h1, "R2 master=1");
    wr(A_MER, 32'h2); rd(A_MER, 32'h2, "R2 master=2");
    // R8 no capture with hardware enable off
    wr(A_MER, 32'h1);
    pulse(1);
    irqIn[5] = 1'b1; waitc(3); irqIn[5] = 1'b0; waitc(1);
    wr(A_MER, 32'h3); waitc(2);
    rd(A_STAT, 32'h0, "R8 no capture while disabled");
    // R8 edge capture, held-high edge does not re-latch
    pulse(2);
    rd(A_STAT, 32'h04, "R8 edge latched after pulse");
    @(negedge clk); irqIn[3] = 1'b1; waitc(2);
    wr(A_ACK, 32'h08); waitc(2);
    rd(A_STAT, 32'h04, "R8 held edge stays clear after ack");
    irqIn[3] = 1'b0;
    // R10 / R9 enable gating
    rd(A_PEND, 32'h0, "R10 pending masked by enable");
    rd(A_VEC, 32'hFFFF_FFFF, "R6 vector idle when masked");
    chkReq(1'b0, "R9 no pending");
    // R5 direct enable, upper bits dropped
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, 32'h0000_00FF, "R10 enable bits above count read zero");
    rd(A_PEND, 32'h04, "R10 pending = status & enable");
    rd(A_VEC, 32'd2, "R6 vector index 2");
    chkReq(1'b1, "R9 both master bits");
    wr(A_MER, 32'h1); chkReq(1'b0, "R9 master=1");
    wr(A_MER, 32'h2); chkReq(1'b0, "R9 master=2");
    wr(A_MER, 32'h3); chkReq(1'b1, "R9 master=3");
    // lowest index wins
    pulse(0);
    rd(A_VEC, 32'd0, "R6 lowest pending index");
    wr(A_EN, 32'h0);
    rd(A_EN, 32'h0, "R5 enable replaced by zero");
    chkReq(1'b0, "R5 zero enable drops request");
    // R4 set/clear aliases
    wr(A_SET, 32'h05); rd(A_EN, 32'h05, "R4 set-enable");
    wr(A_SET, 32'h02); rd(A_EN, 32'h07, "R4 set-enable ORs");
    rd(A_VEC, 32'd0, "R6 vector with bits 0 and 2 pending");
    wr(A_CLR, 32'h03); rd(A_EN, 32'h04, "R4 clear-enable");
    rd(A_VEC, 32'd2, "R6 vector after clear-enable");
    // R3 acknowledge
    wr(A_ACK, 32'h05);
    rd(A_STAT, 32'h0, "R3 ack clears selected bits");
    rd(A_VEC, 32'hFFFF_FFFF, "R6 vector idle after ack");
    chkReq(1'b0, "R3 request gone after ack");
    // R7 level relatch
    @(negedge clk); irqIn[6] = 1'b1; waitc(2);
    rd(A_STAT, 32'h40, "R7 level latched");
    wr(A_SET, 32'h40);
    rd(A_VEC, 32'd6, "R6 vector index 6");
    wr(A_ACK, 32'h40); waitc(1);
    rd(A_STAT, 32'h40, "R7 level relatches while high");
    chkReq(1'b1, "R7 request persists");
    irqIn[6] = 1'b0; waitc(1);
    wr(A_ACK, 32'h40);
    rd(A_STAT, 32'h0, "R7 level clears once low");
    // R3 acknowledge all
    pulse(1);
    @(negedge clk); irqIn[7] = 1'b1; waitc(2); irqIn[7] = 1'b0; waitc(1);
    rd(A_STAT, 32'h82, "R3 two events latched");
    wr(A_ACK, 32'hFFFF_FFFF);
    rd(A_STAT, 32'h0, "R3 ack all ones clears all");
    rd(A_ACK, 32'h0, "R1 acknowledge reads zero");
    waitc(2);
    if (expQ.size() != 0) begin
      errors++; checks++;
      $display("FAIL R1 missing read results got=%0d exp=0", expQ.size());
    end
    done = 1;
    finishRun();
  end
endmodule